// File: doc/BRIEF.md
# Current and Saved Status Registers

This block holds a processor's current status word and one saved copy of it. The current word carries four condition flags, two interrupt mask bits and a five-bit mode field. Software-style writes reach either word through one write port. A qualifier selects whether the write touches only the flags or the whole word. A read port returns either word, selected by one input, in the same cycle. A save strobe copies the current word into the saved word at the next clock edge, the way an exception entry would.

Protection depends on the current mode. In 32-bit user mode (10000), a write to the current word can change only the flags. Any read or write of the saved word in that mode is refused. A refused access, and any full write carrying a mode code that is not recognised, raises a one-cycle error output on the following cycle. Instruction decode, register banking and exception vectoring are handled elsewhere.

Top module: `status_regs`

## Requirements
- R1: After reset the mode is 00011 (SVC26), both mask bits are 1, the flags are 0, the saved word reads 0 and accErr is 0.
- R2: A flags-only write to the current word loads bits 31..28 (N,Z,C,V from high to low) and leaves the masks and mode unchanged, whatever the data's other bits hold.
- R3: In any mode other than 10000, a full write to the current word loads the flags from bits 31..28, the IRQ mask from bit 7, the FIQ mask from bit 6 and the mode from bits 4..0.
- R4: In mode 10000, a full write to the current word changes only the flags, raises no error and leaves the masks and mode unchanged.
- R5: Bits 27..8 and bit 5 always read as 0, even after writing ones to them.
- R6: With rdEn high, rdData shows the current word when rdSaved is 0 and the saved word when rdSaved is 1, in the same cycle.
- R7: In mode 10000, a read of the saved word returns 0 and a write to the saved word is refused. Either access sets accErr high for exactly the one cycle after the access.
- R8: A save strobe makes the saved word equal to the current word as it was before that edge. An accepted write to the saved word in the same cycle takes precedence over the strobe.
- R9: The recognised modes are 00000, 00001, 00010, 00011, 10000, 10001, 10010, 10011, 10111 and 11011. A full write with any other mode code keeps the old mode, still loads the flags and masks, and sets accErr for one cycle.
- R10: Outside mode 10000, writes to the saved word follow the same rules: flags-only writes change only its flags, and full writes load its flags, masks and recognised mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request |
| wrFlagsOnly | input | 1 | 1: write flags only; 0: full write |
| wrSaved | input | 1 | Write target: 0 current, 1 saved |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read request |
| rdSaved | input | 1 | Read source: 0 current, 1 saved |
| saveStb | input | 1 | Copy current word into saved word |
| rdData | output | 32 | Read data (combinational) |
| flags | output | 4 | N,Z,C,V of the current word |
| irqMask | output | 1 | Current IRQ mask |
| fiqMask | output | 1 | Current FIQ mask |
| mode | output | 5 | Current mode |
| accErr | output | 1 | One-cycle access error |

## Verification
Read data is combinational, so the bench checks rdData one nanosecond after driving a request, before the next rising edge. Register contents, the flag, mask and mode outputs, and accErr all change at the rising edge that consumes a request. The bench drives each request on a falling edge and checks these results at the next falling edge. An idle cycle follows each refused access, and at that cycle the bench expects accErr to have dropped again. The sweep tries all 32 mode codes as full writes.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int WORD_W  = 32;
  localparam int FLAG_W  = 4;
  localparam int MODE_W  = 5;
  localparam int FLAG_LO = WORD_W - FLAG_W;
  localparam int IRQ_POS = 7;
  localparam int FIQ_POS = 6;
  localparam int RSV_W   = FLAG_LO - IRQ_POS - 1;

  localparam logic [MODE_W-1:0] MODE_SVC26 = 5'b00011;
  localparam logic [MODE_W-1:0] MODE_USR32 = 5'b10000;

  typedef struct packed {
    logic curFlagWe;
    logic curCtrlWe;
    logic savFlagWe;
    logic savCtrlWe;
    logic savCopy;
    logic rdBlock;
    logic errNow;
  } psrStrobe_t;

  function automatic logic isLegalMode(input logic [MODE_W-1:0] m);
    case (m)
      5'b00000, 5'b00001, 5'b00010, 5'b00011,
      5'b10000, 5'b10001, 5'b10010, 5'b10011,
      5'b10111, 5'b11011: isLegalMode = 1'b1;
      default:            isLegalMode = 1'b0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] packWord(
    input logic [FLAG_W-1:0] f, input logic i, input logic q,
    input logic [MODE_W-1:0] m);
    packWord = {f, {RSV_W{1'b0}}, i, q, 1'b0, m};
  endfunction
endpackage

// File: rtl/status_ctrl.sv
module status_ctrl
  import status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrFlagsOnly,
  input  logic              wrSaved,
  input  logic [MODE_W-1:0] wrMode,
  input  logic              rdEn,
  input  logic              rdSaved,
  input  logic              saveStb,
  input  logic [MODE_W-1:0] curMode,
  output psrStrobe_t        stb,
  output logic              accErr
);
  logic user32;
  logic reqCur;
  logic reqSav;

  assign user32 = (curMode == MODE_USR32);
  assign reqCur = wrEn && !wrSaved;
  assign reqSav = wrEn && wrSaved;

  always_comb begin
    stb.curFlagWe = reqCur;
    stb.curCtrlWe = reqCur && !wrFlagsOnly && !user32;
    stb.savFlagWe = reqSav && !user32;
    stb.savCtrlWe = reqSav && !user32 && !wrFlagsOnly;
    stb.savCopy   = saveStb && !(reqSav && !user32);
    stb.rdBlock   = rdEn && rdSaved && user32;
    stb.errNow    = (rdEn && rdSaved && user32) || (reqSav && user32) ||
                    (wrEn && !wrFlagsOnly && !user32 && !isLegalMode(wrMode));
  end

  always_ff @(posedge clk) begin
    if (!rstN) accErr <= 1'b0;
    else       accErr <= stb.errNow;
  end

  // R7: a refused saved-word access shows up on the error output one cycle later
  a_r7_err_follows: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSaved && curMode == MODE_USR32) |=> accErr);

  // R4: a full write in 32-bit user mode is never reported as an error
  a_r4_no_user_err: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSaved && !rdEn && curMode == MODE_USR32) |=> !accErr);
endmodule

// File: rtl/status_data.sv
module status_data
  import status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  psrStrobe_t        stb,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdSaved,
  output logic [WORD_W-1:0] rdData,
  output logic [FLAG_W-1:0] curFlags,
  output logic              curIrq,
  output logic              curFiq,
  output logic [MODE_W-1:0] curMode
);
  logic [FLAG_W-1:0] savFlags;
  logic              savIrq;
  logic              savFiq;
  logic [MODE_W-1:0] savMode;
  logic [WORD_W-1:0] curWord;
  logic [WORD_W-1:0] savWord;
  logic              newModeOk;
  logic              unusedWrBits;

  assign newModeOk    = isLegalMode(wrData[MODE_W-1:0]);
  assign unusedWrBits = ^{wrData[FLAG_LO-1:IRQ_POS+1], wrData[MODE_W]};
  assign curWord      = packWord(curFlags, curIrq, curFiq, curMode);
  assign savWord      = packWord(savFlags, savIrq, savFiq, savMode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curFlags <= '0;
      curIrq   <= 1'b1;
      curFiq   <= 1'b1;
      curMode  <= MODE_SVC26;
    end else begin
      if (stb.curFlagWe) curFlags <= wrData[WORD_W-1:FLAG_LO];
      if (stb.curCtrlWe) begin
        curIrq <= wrData[IRQ_POS];
        curFiq <= wrData[FIQ_POS];
        if (newModeOk) curMode <= wrData[MODE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savFlags <= '0;
      savIrq   <= 1'b0;
      savFiq   <= 1'b0;
      savMode  <= '0;
    end else if (stb.savFlagWe) begin
      savFlags <= wrData[WORD_W-1:FLAG_LO];
      if (stb.savCtrlWe) begin
        savIrq <= wrData[IRQ_POS];
        savFiq <= wrData[FIQ_POS];
        if (newModeOk) savMode <= wrData[MODE_W-1:0];
      end
    end else if (stb.savCopy) begin
      savFlags <= curFlags;
      savIrq   <= curIrq;
      savFiq   <= curFiq;
      savMode  <= curMode;
    end
  end

  always_comb begin
    if (stb.rdBlock)  rdData = '0;
    else if (rdSaved) rdData = savWord;
    else              rdData = curWord;
  end

  // R9: the mode register only ever holds a recognised code
  a_r9_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    isLegalMode(curMode));

  // R4: once in 32-bit user mode the control bits of the current word stay put
  a_r4_user_locked: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_USR32) |=> (curMode == MODE_USR32) && $stable(curIrq) && $stable(curFiq));

  // R8: a save strobe captures the pre-edge current word
  a_r8_copy: assert property (@(posedge clk) disable iff (!rstN)
    stb.savCopy |=> (savWord == $past(curWord)));

  // R2: a flags-only write leaves the control bits alone
  a_r2_ctrl_kept: assert property (@(posedge clk) disable iff (!rstN)
    (stb.curFlagWe && !stb.curCtrlWe) |=> $stable(curMode) && $stable(curIrq) && $stable(curFiq));

  // R7: in 32-bit user mode the saved word is altered only by a save strobe
  a_r7_saved_hold: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_USR32 && !stb.savCopy) |=> $stable(savWord));
endmodule

// File: rtl/status_regs.sv
module status_regs
  import status_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrFlagsOnly,
  input  logic        wrSaved,
  input  logic [31:0] wrData,
  input  logic        rdEn,
  input  logic        rdSaved,
  input  logic        saveStb,
  output logic [31:0] rdData,
  output logic [3:0]  flags,
  output logic        irqMask,
  output logic        fiqMask,
  output logic [4:0]  mode,
  output logic        accErr
);
  psrStrobe_t stb;

  status_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrFlagsOnly (wrFlagsOnly),
    .wrSaved     (wrSaved),
    .wrMode      (wrData[MODE_W-1:0]),
    .rdEn        (rdEn),
    .rdSaved     (rdSaved),
    .saveStb     (saveStb),
    .curMode     (mode),
    .stb         (stb),
    .accErr      (accErr)
  );

  status_data uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .rdSaved  (rdSaved),
    .rdData   (rdData),
    .curFlags (flags),
    .curIrq   (irqMask),
    .curFiq   (fiqMask),
    .curMode  (mode)
  );

  // R5: reserved positions never carry a one
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[FLAG_LO-1:IRQ_POS+1] == '0) && !rdData[MODE_W]);

  // R7: a blocked saved-word read returns zero
  a_r7_blocked_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSaved && mode == MODE_USR32) |-> (rdData == '0));
endmodule

// File: tb/sim_status_regs.sv
module sim_status_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrFlagsOnly = 1'b0, wrSaved = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0, rdSaved = 1'b0, saveStb = 1'b0;
  logic [31:0] rdData;
  logic [3:0]  flags;
  logic        irqMask, fiqMask, accErr;
  logic [4:0]  mode;

  int nChecks = 0;
  int nFails  = 0;

  logic [3:0]  eF;
  logic        eI, eQ;
  logic [4:0]  eM;
  logic [31:0] eS;
  logic        eErr;

  always #4 clk = ~clk;

  status_regs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrFlagsOnly(wrFlagsOnly),
    .wrSaved(wrSaved), .wrData(wrData), .rdEn(rdEn), .rdSaved(rdSaved),
    .saveStb(saveStb), .rdData(rdData), .flags(flags), .irqMask(irqMask),
    .fiqMask(fiqMask), .mode(mode), .accErr(accErr)
  );

  function automatic logic known(input logic [4:0] m);
    known = (m == 5'd0) || (m == 5'd1) || (m == 5'd2) || (m == 5'd3) ||
            (m == 5'd16) || (m == 5'd17) || (m == 5'd18) || (m == 5'd19) ||
            (m == 5'd23) || (m == 5'd27);
  endfunction

  function automatic logic [31:0] mkWord(input logic [3:0] f, input logic i,
                                         input logic q, input logic [4:0] m);
    mkWord = {f, 20'd0, i, q, 1'b0, m};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one request on a falling edge, check read data now, state and error after the next rising edge.
  task automatic step(input string req, input logic we, input logic fo, input logic ws,
                      input logic [31:0] d, input logic re, input logic rs, input logic sv);
    logic        u32;
    logic [31:0] cw;
    logic [31:0] rdExp;
    u32 = (eM == 5'b10000);
    cw  = mkWord(eF, eI, eQ, eM);
    wrEn = we; wrFlagsOnly = fo; wrSaved = ws; wrData = d;
    rdEn = re; rdSaved = rs; saveStb = sv;
    #1;
    if (re) begin
      rdExp = (rs && u32) ? 32'd0 : (rs ? eS : cw);
      check(req, rdData, rdExp);
    end
    eErr = (re && rs && u32) || (we && ws && u32) || (we && !fo && !u32 && !known(d[4:0]));
    if (we && ws && !u32) begin
      eS[31:28] = d[31:28];
      if (!fo) begin
        eS[7] = d[7];
        eS[6] = d[6];
        if (known(d[4:0])) eS[4:0] = d[4:0];
      end
    end else if (sv) begin
      eS = cw;
    end
    if (we && !ws) begin
      eF = d[31:28];
      if (!fo && !u32) begin
        eI = d[7];
        eQ = d[6];
        if (known(d[4:0])) eM = d[4:0];
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(req, {flags, 20'd0, irqMask, fiqMask, 1'b0, mode}, mkWord(eF, eI, eQ, eM));
    check(req, {31'd0, accErr}, {31'd0, eErr});
    wrEn = 1'b0; wrFlagsOnly = 1'b0; wrSaved = 1'b0; wrData = '0;
    rdEn = 1'b0; rdSaved = 1'b0; saveStb = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    eF = 4'd0; eI = 1'b1; eQ = 1'b1; eM = 5'b00011; eS = '0; eErr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, current and saved readback
    check("R1", {flags, 20'd0, irqMask, fiqMask, 1'b0, mode}, 32'h0000_00C3);
    check("R1", {31'd0, accErr}, 32'd0);
    step("R1", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0);
    step("R1", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0);

    // R3 / R9: sweep every mode code (32-bit user left for last), reserved bits set
    for (int m = 0; m < 32; m++) begin
      if (m != 16) begin
        logic [4:0] mm;
        mm = 5'(m);
        step(known(mm) ? "R3" : "R9", 1'b1, 1'b0, 1'b0,
             {4'(m) ^ 4'hA, 20'hFFFFF, mm[0], mm[1], 1'b1, mm}, 1'b0, 1'b0, 1'b0);
        // R5: reserved positions read back as zero
        step("R5", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0);
      end
    end
    // back to a privileged mode with known masks
    step("R3", 1'b1, 1'b0, 1'b0, 32'h9000_0093, 1'b0, 1'b0, 1'b0);

    // R2: flags-only write carrying a user-mode code and cleared masks
    step("R2", 1'b1, 1'b1, 1'b0, 32'h5FFF_FF10, 1'b1, 1'b0, 1'b0);
    step("R2", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0);

    // R10: full then flags-only write to the saved word, read through R6
    step("R10", 1'b1, 1'b0, 1'b1, 32'h9000_00D1, 1'b0, 1'b0, 1'b0);
    step("R6", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0);
    step("R10", 1'b1, 1'b1, 1'b1, 32'h6FFF_FF12, 1'b0, 1'b0, 1'b0);
    step("R6", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0);
    step("R10", 1'b1, 1'b0, 1'b1, 32'hC000_0045, 1'b0, 1'b0, 1'b0);
    step("R9", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0);

    // R8: save strobe, save with a concurrent current write, save against a saved write
    step("R8", 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b1);
    step("R8", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b0, 1'b0, 32'h2000_0082, 1'b0, 1'b0, 1'b1);
    step("R8", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0);
    step("R8", 1'b1, 1'b0, 1'b1, 32'hA000_0057, 1'b0, 1'b0, 1'b1);
    step("R8", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0);

    // enter 32-bit user mode
    step("R3", 1'b1, 1'b0, 1'b0, 32'h3000_0010, 1'b0, 1'b0, 1'b0);
    // R4: full write changes flags only
    step("R4", 1'b1, 1'b0, 1'b0, 32'hF000_00D3, 1'b1, 1'b0, 1'b0);
    step("R4", 1'b1, 1'b0, 1'b0, 32'h1000_00C5, 1'b0, 1'b0, 1'b0);
    // R7: refused saved read, error drops after one cycle
    step("R7", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1, 1'b0);
    step("R7", 1'b0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 1'b0);
    // R7: refused saved write
    step("R7", 1'b1, 1'b0, 1'b1, 32'hF000_00D3, 1'b0, 1'b0, 1'b0);
    step("R7", 1'b0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule